// File: doc/BRIEF.md
# Triangular-Basis Neural Amplitude Predistorter

This block turns a sample's amplitude into a predistorted amplitude before it reaches a nonlinear tube-type power amplifier. It is a fixed-weight perceptron with one input and one output. The scalar input goes to a bank of hidden neurons. Each neuron scales the input by its own weight, adds its own bias, and passes the result through a triangular activation. A linear output neuron adds up the weighted activations and an output bias. Every weight and bias is an elaboration-time parameter, so the whole network is made of constant multipliers and adders. The same block, built with a second set of constants, can serve as the phase-correction network.

Samples are 16-bit signed fixed point with 10 fractional bits, so one code step is 1/1024 and the range is [-32.0, 32.0). Parameters are given as integer codes in that format. The block is a three-stage pipeline: affine, activation, output sum. It takes one sample per clock, and a valid flag travels alongside the data.

Top module: `tribas_mlp_predistorter`

## Requirements
- R1: A sample presented with `in_valid` high at a rising edge appears on the outputs after the third rising edge that follows. `out_valid` equals `in_valid` delayed by exactly three clocks.
- R2: The block accepts a new sample on every clock with no stall. Every accepted sample produces exactly one output, in the order the samples were accepted.
- R3: Each hidden activation is 1 − |u| when |u| ≤ 1, and 0 otherwise. It is computed exactly with 20 fractional bits.
- R4: Each hidden pre-activation is u = w·p + b, kept at full precision with no rounding. Here p is the input code, w the neuron's weight code and b its bias code, all with 10 fractional bits.
- R5: The output is the sum of weight × activation over all neurons plus the output bias, rounded to 10 fractional bits. Rounding is to nearest, and exact halves round toward positive infinity.
- R6: An output above 32767 or below −32768 (in code units) is clamped to that limit.
- R7: A weight or bias code outside the 16-bit signed range is clamped to the nearest limit at elaboration, and a warning line is printed for it.
- R8: While reset is high, and on the first clock after reset, `out_valid` is 0 and `out_amp` is 0.
- R9: While `out_valid` is low, `out_amp` keeps its last value. Input data presented with `in_valid` low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_amp | input | DATA_W | Input amplitude, signed, FRAC_W fractional bits |
| out_valid | output | 1 | Output sample qualifier |
| out_amp | output | DATA_W | Predistorted amplitude, signed, FRAC_W fractional bits |

## Verification
The bench uses the default 16-bit format with four neurons, but replaces the weights and biases with its own constants. Two of those constants lie outside the 16-bit range, so clamping at elaboration (R7) shapes the results. The constants are also chosen so that the output reaches both clamp limits and many outputs need rounding. Every one of the 65536 input codes is swept back to back, and the expected result for each is computed with wide integer arithmetic. A second sweep leaves gaps in the valid signal and drives junk data during the gaps. This shows that idle data is ignored and the output holds during the gaps.

// File: rtl/tbmlp_pkg.sv
package tbmlp_pkg;

  // Clamp an integer code into the signed range of a w-bit word.
  function automatic int clamp_code(input int v, input int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/tbmlp_hidden_unit.sv
module tbmlp_hidden_unit #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 10,
  parameter int W_CODE = 1024,
  parameter int B_CODE = 0,
  localparam int U_FRAC = 2 * FRAC_W,
  localparam int ACT_W  = U_FRAC + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     act_valid,
  output logic        [ACT_W-1:0]  act_q
);
  localparam int U_W = 2 * DATA_W + 1;
  localparam logic signed [DATA_W-1:0] W_Q = DATA_W'(tbmlp_pkg::clamp_code(W_CODE, DATA_W));
  localparam logic signed [DATA_W-1:0] B_Q = DATA_W'(tbmlp_pkg::clamp_code(B_CODE, DATA_W));
  localparam logic signed [U_W-1:0] ONE_S = {{(U_W-U_FRAC-1){1'b0}}, 1'b1, {U_FRAC{1'b0}}};
  localparam logic        [U_W-1:0] ONE_U = {{(U_W-U_FRAC-1){1'b0}}, 1'b1, {U_FRAC{1'b0}}};

  // Stage 1: affine term at full precision
  logic signed [U_W-1:0] p_ext, w_ext, b_ext, u_c, u_q;
  logic                  aff_valid;

  assign p_ext = U_W'(in_data);
  assign w_ext = U_W'(W_Q);
  assign b_ext = U_W'(B_Q) <<< FRAC_W;
  assign u_c   = p_ext * w_ext + b_ext;

  always_ff @(posedge clk) begin
    if (rst) aff_valid <= 1'b0;
    else     aff_valid <= in_valid;
    if (in_valid) u_q <= u_c;
  end

  // Stage 2: triangular activation
  logic [U_W-1:0]   mag_c;
  logic [ACT_W-1:0] act_c;

  assign mag_c = u_q[U_W-1] ? U_W'(-u_q) : U_W'(u_q);
  assign act_c = (mag_c <= ONE_U) ? ACT_W'(ONE_U - mag_c) : '0;

  always_ff @(posedge clk) begin
    if (rst) act_valid <= 1'b0;
    else     act_valid <= aff_valid;
    if (aff_valid) act_q <= act_c;
  end

  AST_ACT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> (act_q <= ACT_W'(ONE_U))); // R3

  AST_ACT_ONLY_INSIDE: assert property (@(posedge clk) disable iff (rst)
    (act_valid && (act_q != '0)) |-> (($past(u_q) > -ONE_S) && ($past(u_q) < ONE_S))); // R3

endmodule

// File: rtl/tbmlp_output_sum.sv
module tbmlp_output_sum #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 10,
  parameter int N_HID  = 4,
  parameter int OUT_W [N_HID] = '{5471, -340, -6752, -3838},
  parameter int OUT_B  = 8643,
  localparam int ACT_W = 2 * FRAC_W + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           act_valid,
  input  logic [N_HID-1:0][ACT_W-1:0]    acts,
  output logic                           o_valid,
  output logic signed [DATA_W-1:0]       o_data
);
  localparam int SHIFT = 2 * FRAC_W;
  localparam int ACC_W = DATA_W + ACT_W + 1 + $clog2(N_HID) + 2;
  localparam logic signed [DATA_W-1:0] B_Q = DATA_W'(tbmlp_pkg::clamp_code(OUT_B, DATA_W));
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] HI_A = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] LO_A = -HI_A - ACC_W'(1);

  logic signed [ACC_W-1:0] term [N_HID];

  for (genvar gi = 0; gi < N_HID; gi++) begin : g_term
    localparam logic signed [DATA_W-1:0] WQ = DATA_W'(tbmlp_pkg::clamp_code(OUT_W[gi], DATA_W));
    assign term[gi] = ACC_W'(WQ) * ACC_W'($signed({1'b0, acts[gi]}));
  end

  logic signed [ACC_W-1:0] acc_c, rnd_c;
  logic signed [DATA_W-1:0] sat_c;

  always_comb begin
    acc_c = ACC_W'(B_Q) <<< SHIFT;
    for (int i = 0; i < N_HID; i++) acc_c = acc_c + term[i];
    rnd_c = (acc_c + HALF) >>> SHIFT;
    if (rnd_c > HI_A)      sat_c = HI_A[DATA_W-1:0];
    else if (rnd_c < LO_A) sat_c = LO_A[DATA_W-1:0];
    else                   sat_c = rnd_c[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else begin
      o_valid <= act_valid;
      if (act_valid) o_data <= sat_c;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> $stable(o_data)); // R9

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (o_valid && $past(rnd_c > HI_A)) |-> (o_data == HI_A[DATA_W-1:0])); // R6

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (o_valid && $past(rnd_c < LO_A)) |-> (o_data == LO_A[DATA_W-1:0])); // R6

endmodule

// File: rtl/tribas_mlp_predistorter.sv
module tribas_mlp_predistorter #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 10,
  parameter int N_HID  = 4,
  parameter int HID_W [N_HID] = '{-1582, -103, 87, -300},
  parameter int HID_B [N_HID] = '{25255, 1023, -300, 10},
  parameter int OUT_W [N_HID] = '{5471, -340, -6752, -3838},
  parameter int OUT_B  = 8643
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_amp,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_amp
);
  localparam int ACT_W = 2 * FRAC_W + 1;

  logic [N_HID-1:0]             lane_valid;
  logic [N_HID-1:0][ACT_W-1:0]  lane_act;

  for (genvar gi = 0; gi < N_HID; gi++) begin : g_hidden
    tbmlp_hidden_unit #(
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W),
      .W_CODE (HID_W[gi]),
      .B_CODE (HID_B[gi])
    ) u_unit (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_amp),
      .act_valid (lane_valid[gi]),
      .act_q     (lane_act[gi])
    );
  end

  tbmlp_output_sum #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .N_HID  (N_HID),
    .OUT_W  (OUT_W),
    .OUT_B  (OUT_B)
  ) u_sum (
    .clk       (clk),
    .rst       (rst),
    .act_valid (lane_valid[0]),
    .acts      (lane_act),
    .o_valid   (out_valid),
    .o_data    (out_amp)
  );

  // Elaboration-time range check of the constants
  initial begin
    for (int i = 0; i < N_HID; i++) begin
      if (tbmlp_pkg::clamp_code(HID_W[i], DATA_W) != HID_W[i])
        $display("WARNING: hidden weight %0d code %0d clamped", i, HID_W[i]);
      if (tbmlp_pkg::clamp_code(HID_B[i], DATA_W) != HID_B[i])
        $display("WARNING: hidden bias %0d code %0d clamped", i, HID_B[i]);
      if (tbmlp_pkg::clamp_code(OUT_W[i], DATA_W) != OUT_W[i])
        $display("WARNING: output weight %0d code %0d clamped", i, OUT_W[i]);
    end
    if (tbmlp_pkg::clamp_code(OUT_B, DATA_W) != OUT_B)
      $display("WARNING: output bias code %0d clamped", OUT_B);
  end

  AST_LANES_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ((&lane_valid) || !(|lane_valid))); // R2

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3)) |-> (out_valid == $past(in_valid, 3))); // R1

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && (out_amp == '0))); // R8

endmodule

// File: tb/tribas_mlp_predistorter_test.sv
`timescale 1ns/1ps
module tribas_mlp_predistorter_test;
  localparam int DW = 16;
  localparam int FW = 10;
  localparam int NH = 4;
  // Bench constants; HB[3] and OW[1] are out of range on purpose (R7)
  localparam int HW [NH] = '{1024, -2048, 512, 3072};
  localparam int HB [NH] = '{0, 1024, -10240, -40000};
  localparam int OW [NH] = '{30720, 50000, -30720, -30720};
  localparam int OB = -5120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_amp = '0;
  logic out_valid;
  logic signed [DW-1:0] out_amp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];
  logic signed [DW-1:0] last_out = '0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  tribas_mlp_predistorter #(
    .DATA_W(DW), .FRAC_W(FW), .N_HID(NH),
    .HID_W(HW), .HID_B(HB), .OUT_W(OW), .OUT_B(OB)
  ) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_amp(in_amp),
    .out_valid(out_valid), .out_amp(out_amp)
  );

  function automatic longint clampw(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Expected output from R3..R7 arithmetic
  function automatic longint model(longint p);
    longint one, u, m, a, s;
    one = 64'sd1 <<< 20;
    s = clampw(OB) <<< 20;
    for (int i = 0; i < NH; i++) begin
      u = clampw(HW[i]) * p + (clampw(HB[i]) <<< 10);
      m = (u < 0) ? -u : u;
      a = (m <= one) ? one - m : 0;
      s = s + clampw(OW[i]) * a;
    end
    return (s + (64'sd1 <<< 19)) >>> 20;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(int p, bit v);
    longint r;
    @(negedge clk);
    in_valid = v;
    in_amp = DW'(p);
    if (v) begin
      r = model(p);
      exp_q.push_back(int'(clampw(r)));
      tag_q.push_back((r > 32767 || r < -32768) ? "R6" : "R5 (R3 R4 R7)");
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R2 extra output", out_amp, 0);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_amp == DW'(e), t, out_amp, e);
        end
      end else begin
        check(out_amp == last_out, "R9 hold", out_amp, last_out);
      end
      last_out = out_amp;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R8 valid in reset", out_valid, 0);
    check(out_amp == '0, "R8 data in reset", out_amp, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid after reset", out_valid, 0);
    check(out_amp == '0, "R8 data after reset", out_amp, 0);
    mon_on = 1'b1;

    // R1: single sample, latency of three clocks
    drive(0, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R1 early 1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 early 2", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R1 on time", out_valid, 1);
    repeat (3) @(negedge clk);

    // R2: every code back to back
    for (int p = -32768; p <= 32767; p++) drive(p, 1'b1);
    drive(0, 1'b0);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R2 all samples out", exp_q.size(), 0);

    // R9: gapped stream with junk data while idle
    for (int k = 0; k < 3000; k++) begin
      if (k % 3 == 2) drive((k * 977) % 32768, 1'b0);
      else            drive(-32768 + k * 21, 1'b1);
    end
    drive(12345, 1'b0);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R2 gapped samples out", exp_q.size(), 0);
    check(out_valid == 1'b0, "R9 idle at end", out_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule